// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel address into a DIMM index, a rank number and an address inside that rank. A table of eight rank rules is applied to the address. Each rule holds an upper limit and four way entries, and each way entry holds a rank number and a signed offset. The offset counts virtual-rank units of 2^28 bytes.

The first rule whose window contains the address is used. A rule's window starts at the previous rule's limit (zero for rule 0) and stops just below its own limit. Two address bits pick one of the four way entries. The page-policy input decides which two bits these are. The rule's interleave factor is not configured. It is inferred from how many way entries repeat the rank held by way 0, and it sets how far the offset-adjusted address is shifted down.

The table is supplied as static configuration vectors. One request is accepted per cycle, and the result appears one cycle later.

Top module: `rank_ilv_decoder`

## Requirements
- R1: A request uses the lowest-numbered rule i for which caddr < limit[i] and caddr >= limit[i-1]. For rule 0 the lower bound is 0. Rule i's limit sits at bits [i*CADDR_W +: CADDR_W] of `rule_limit`.
- R2: When `closed_page` is 1, the way is caddr[7:6] and the rank address keeps caddr[5:0] unchanged.
- R3: When `closed_page` is 0, the way is caddr[13:12] and the rank address keeps caddr[11:0] unchanged.
- R4: A rule interleaves by 1 when all four way ranks equal way 0's rank. It interleaves by 2 when only some of ways 1 to 3 equal way 0's rank, and by 4 when none of them do. Way j of rule i sits at slot i*4+j of `way_rank` and `way_offset`.
- R5: The rank address is ((caddr + offset*2^28) mod 2^CADDR_W) shifted right by log2(interleave). The kept low bits of this result are then replaced by caddr's own low bits. The offset is two's complement.
- R6: A hit reports the selected way's rank on `out_rank`, and `out_dimm` = rank >> 2.
- R7: When no rule matches, `out_miss` is 1 and `out_dimm`, `out_rank` and `out_rank_addr` are all ones.
- R8: `out_valid` is `in_valid` delayed by one cycle. When `in_valid` is 0, the result outputs keep their values.
- R9: While the block is in reset and just after reset, `out_valid` and `out_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe |
| caddr | input | CADDR_W | Channel address |
| closed_page | input | 1 | 1 selects the closed-page way bits, 0 the open-page way bits |
| rule_limit | input | NRULE*CADDR_W | Upper limit of each rule |
| way_rank | input | NRULE*4*RANK_W | Rank number of each way entry |
| way_offset | input | NRULE*4*OFF_W | Signed offset of each way entry, in 2^28-byte units |
| out_valid | output | 1 | Result strobe |
| out_miss | output | 1 | No rule matched |
| out_dimm | output | RANK_W-2 | DIMM index |
| out_rank | output | RANK_W | Rank number |
| out_rank_addr | output | CADDR_W | Address within the rank |

## Verification
The assertions check on every cycle that the result strobe follows the request one cycle later and that the outputs hold while idle. They also check that a miss drives all-ones fields, that the DIMM index matches the reported rank, and that the preserved low bits match the request under both page policies.

Some behaviours can only be shown by the bench scenarios: which rule is chosen at limit boundaries, the inferred interleave factor, the way selection and the offset arithmetic, including negative offsets. The bench compares each of these against a reference model.

// File: rtl/rir_pkg.sv
`timescale 1ns/1ps
package rir_pkg;
  // interleave factor, encoded as its right-shift amount
  typedef enum logic [1:0] {
    ILV_1 = 2'd0,
    ILV_2 = 2'd1,
    ILV_4 = 2'd2
  } ilv_e;

  localparam int NWAY = 4;
endpackage

// File: rtl/rir_rule_match.sv
`timescale 1ns/1ps
module rir_rule_match #(
  parameter int CADDR_W = 37,
  parameter int NRULE   = 8,
  localparam int IDX_W  = (NRULE > 1) ? $clog2(NRULE) : 1
) (
  input  logic [CADDR_W-1:0]       caddr,
  input  logic [NRULE*CADDR_W-1:0] limits,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx
);
  logic [CADDR_W-1:0] lo_bound;
  logic [CADDR_W-1:0] hi_bound;

  // first rule whose [previous limit, own limit) window holds the address
  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    lo_bound = '0;
    hi_bound = '0;
    for (int i = 0; i < NRULE; i++) begin
      hi_bound = limits[i*CADDR_W +: CADDR_W];
      if (!hit && (caddr >= lo_bound) && (caddr < hi_bound)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
      lo_bound = hi_bound;
    end
  end
endmodule

// File: rtl/rir_ilv_factor.sv
`timescale 1ns/1ps
module rir_ilv_factor
  import rir_pkg::*;
#(
  parameter int RANK_W = 4
) (
  input  logic [NWAY*RANK_W-1:0] ranks,
  output ilv_e                   ilv
);
  logic [RANK_W-1:0] r0;
  logic [NWAY-1:1]   same;

  assign r0 = ranks[0 +: RANK_W];

  for (genvar w = 1; w < NWAY; w++) begin : g_cmp
    assign same[w] = (ranks[w*RANK_W +: RANK_W] == r0);
  end

  always_comb begin
    if (&same)      ilv = ILV_1;
    else if (|same) ilv = ILV_2;
    else            ilv = ILV_4;
  end
endmodule

// File: rtl/rir_rank_calc.sv
`timescale 1ns/1ps
module rir_rank_calc
  import rir_pkg::*;
#(
  parameter int CADDR_W  = 37,
  parameter int OFF_W    = 10,
  parameter int VRANK_LG = 28,
  localparam int EXT_W   = CADDR_W + OFF_W
) (
  input  logic [CADDR_W-1:0] caddr,
  input  logic               closed_page,
  input  logic [OFF_W-1:0]   offset,
  input  ilv_e               ilv,
  output logic [CADDR_W-1:0] rank_addr
);
  logic [EXT_W-1:0]   off_ext;
  logic [EXT_W-1:0]   off_shl;
  logic [CADDR_W-1:0] sum;
  logic [CADDR_W-1:0] quot;
  logic [CADDR_W-1:0] keep_mask;

  // sign extend, scale by the virtual-rank size, wrap to the address width
  assign off_ext = {{CADDR_W{offset[OFF_W-1]}}, offset};
  assign off_shl = off_ext << VRANK_LG;
  assign sum     = caddr + off_shl[CADDR_W-1:0];

  always_comb begin
    unique case (ilv)
      ILV_2:   quot = sum >> 1;
      ILV_4:   quot = sum >> 2;
      default: quot = sum;
    endcase
  end

  assign keep_mask = closed_page ? CADDR_W'(64'h3f) : CADDR_W'(64'hfff);
  assign rank_addr = (quot & ~keep_mask) | (caddr & keep_mask);
endmodule

// File: rtl/rank_ilv_decoder.sv
`timescale 1ns/1ps
module rank_ilv_decoder
  import rir_pkg::*;
#(
  parameter int CADDR_W  = 37,
  parameter int NRULE    = 8,
  parameter int RANK_W   = 4,
  parameter int OFF_W    = 10,
  parameter int VRANK_LG = 28
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [CADDR_W-1:0]            caddr,
  input  logic                          closed_page,
  input  logic [NRULE*CADDR_W-1:0]      rule_limit,
  input  logic [NRULE*NWAY*RANK_W-1:0]  way_rank,
  input  logic [NRULE*NWAY*OFF_W-1:0]   way_offset,
  output logic                          out_valid,
  output logic                          out_miss,
  output logic [RANK_W-3:0]             out_dimm,
  output logic [RANK_W-1:0]             out_rank,
  output logic [CADDR_W-1:0]            out_rank_addr
);
  localparam int IDX_W  = (NRULE > 1) ? $clog2(NRULE) : 1;
  localparam int DIMM_W = RANK_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  // rule search
  logic             hit;
  logic [IDX_W-1:0] idx;

  rir_rule_match #(.CADDR_W(CADDR_W), .NRULE(NRULE)) u_match (
    .caddr  (caddr),
    .limits (rule_limit),
    .hit    (hit),
    .idx    (idx)
  );

  // interleave factor per rule
  ilv_e ilv_v [NRULE];
  for (genvar r = 0; r < NRULE; r++) begin : g_rule
    rir_ilv_factor #(.RANK_W(RANK_W)) u_ilv (
      .ranks (way_rank[r*NWAY*RANK_W +: NWAY*RANK_W]),
      .ilv   (ilv_v[r])
    );
  end

  // way selection
  logic [1:0]              way;
  logic [NWAY*RANK_W-1:0]  sel_ranks;
  logic [NWAY*OFF_W-1:0]   sel_offs;
  logic [RANK_W-1:0]       sel_rank;
  logic [OFF_W-1:0]        sel_off;
  ilv_e                    sel_ilv;
  logic [CADDR_W-1:0]      calc_addr;

  assign way       = closed_page ? caddr[7:6] : caddr[13:12];
  assign sel_ranks = way_rank[idx*NWAY*RANK_W +: NWAY*RANK_W];
  assign sel_offs  = way_offset[idx*NWAY*OFF_W +: NWAY*OFF_W];
  assign sel_rank  = sel_ranks[way*RANK_W +: RANK_W];
  assign sel_off   = sel_offs[way*OFF_W +: OFF_W];
  assign sel_ilv   = ilv_v[idx];

  rir_rank_calc #(
    .CADDR_W (CADDR_W),
    .OFF_W   (OFF_W),
    .VRANK_LG(VRANK_LG)
  ) u_calc (
    .caddr      (caddr),
    .closed_page(closed_page),
    .offset     (sel_off),
    .ilv        (sel_ilv),
    .rank_addr  (calc_addr)
  );

  // next-state
  logic               nxt_miss;
  logic [DIMM_W-1:0]  nxt_dimm;
  logic [RANK_W-1:0]  nxt_rank;
  logic [CADDR_W-1:0] nxt_addr;

  always_comb begin
    if (hit) begin
      nxt_miss = 1'b0;
      nxt_rank = sel_rank;
      nxt_dimm = sel_rank[RANK_W-1:2];
      nxt_addr = calc_addr;
    end else begin
      nxt_miss = 1'b1;
      nxt_rank = '1;
      nxt_dimm = '1;
      nxt_addr = '1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_valid     <= 1'b0;
      out_miss      <= 1'b0;
      out_dimm      <= '0;
      out_rank      <= '0;
      out_rank_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_miss      <= nxt_miss;
        out_dimm      <= nxt_dimm;
        out_rank      <= nxt_rank;
        out_rank_addr <= nxt_addr;
      end
    end
  end
endmodule

// File: rtl/rank_ilv_decoder_chk.sv
`timescale 1ns/1ps
module rank_ilv_decoder_chk #(
  parameter int CADDR_W = 37,
  parameter int RANK_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [CADDR_W-1:0] caddr,
  input logic               closed_page,
  input logic               out_valid,
  input logic               out_miss,
  input logic [RANK_W-3:0]  out_dimm,
  input logic [RANK_W-1:0]  out_rank,
  input logic [CADDR_W-1:0] out_rank_addr
);
  // R8: result strobe one cycle after the request
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && $past(rst_n) |=> out_valid);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_rank_addr) && $stable(out_rank) &&
                  $stable(out_dimm) && $stable(out_miss));

  // R7: miss gives all-ones fields
  a_r7_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> (&out_rank_addr) && (&out_rank) && (&out_dimm));

  // R6: DIMM index follows the reported rank
  a_r6_dimm_rank: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_miss |-> out_dimm == out_rank[RANK_W-1:2]);

  // R2: closed page keeps the 6 low bits
  a_r2_closed_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_miss && $past(closed_page)
      |-> out_rank_addr[5:0] == $past(caddr[5:0]));

  // R3: open page keeps the 12 low bits
  a_r3_open_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_miss && !$past(closed_page)
      |-> out_rank_addr[11:0] == $past(caddr[11:0]));
endmodule

bind rank_ilv_decoder rank_ilv_decoder_chk #(
  .CADDR_W(CADDR_W),
  .RANK_W (RANK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_i),
  .in_valid     (in_valid),
  .caddr        (caddr),
  .closed_page  (closed_page),
  .out_valid    (out_valid),
  .out_miss     (out_miss),
  .out_dimm     (out_dimm),
  .out_rank     (out_rank),
  .out_rank_addr(out_rank_addr)
);

// File: tb/test_rank_ilv_decoder.sv
`timescale 1ns/1ps
module test_rank_ilv_decoder;
  localparam int AW = 37;
  localparam int NR = 8;
  localparam int RW = 4;
  localparam int OW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [AW-1:0] caddr;
  logic closed_page;
  logic [NR*AW-1:0]   rule_limit;
  logic [NR*4*RW-1:0] way_rank;
  logic [NR*4*OW-1:0] way_offset;
  logic out_valid, out_miss;
  logic [RW-3:0] out_dimm;
  logic [RW-1:0] out_rank;
  logic [AW-1:0] out_rank_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rank_ilv_decoder i_rank_ilv_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .caddr(caddr),
    .closed_page(closed_page), .rule_limit(rule_limit), .way_rank(way_rank),
    .way_offset(way_offset), .out_valid(out_valid), .out_miss(out_miss),
    .out_dimm(out_dimm), .out_rank(out_rank), .out_rank_addr(out_rank_addr)
  );

  // table copy held by the bench
  logic [AW-1:0] lim [NR];
  logic [RW-1:0] rk  [NR][4];
  logic [OW-1:0] of  [NR][4];

  function automatic void pack_table();
    for (int i = 0; i < NR; i++) begin
      rule_limit[i*AW +: AW] = lim[i];
      for (int j = 0; j < 4; j++) begin
        way_rank[(i*4+j)*RW +: RW]   = rk[i][j];
        way_offset[(i*4+j)*OW +: OW] = of[i][j];
      end
    end
  endfunction

  // reference built from the requirements
  function automatic void ref_model(input logic [AW-1:0] a, input bit cp,
      output bit miss, output logic [RW-1:0] r, output logic [RW-3:0] d,
      output logic [AW-1:0] ra);
    logic [AW-1:0] base = '0;
    logic [63:0] msk = (64'd1 << AW) - 1;
    miss = 1; r = '1; d = '1; ra = '1;
    for (int i = 0; i < NR; i++) begin
      if (a >= base && a < lim[i]) begin
        int w = cp ? int'(a[7:6]) : int'(a[13:12]);
        int same = 0;
        int sh;
        longint soff = longint'($signed(of[i][w]));
        logic [63:0] sum, q, keep;
        for (int j = 1; j < 4; j++) if (rk[i][j] == rk[i][0]) same++;
        sh = (same == 3) ? 0 : (same > 0) ? 1 : 2;
        sum = (64'(a) + 64'(soff <<< 28)) & msk;
        q = sum >> sh;
        keep = cp ? 64'h3f : 64'hfff;
        ra = AW'((q & ~keep) | (64'(a) & keep));
        r = rk[i][w];
        d = r[RW-1:2];
        miss = 0;
        break;
      end
      base = lim[i];
    end
  endfunction

  function automatic logic [AW-1:0] rnd_addr();
    return {$urandom(), $urandom()} % (64'd1 << AW);
  endfunction

  task automatic txn(input logic [AW-1:0] a, input bit cp, input string tag);
    bit em; logic [RW-1:0] er; logic [RW-3:0] ed; logic [AW-1:0] ea;
    @(negedge clk);
    in_valid = 1; caddr = a; closed_page = cp;
    ref_model(a, cp, em, er, ed, ea);
    @(negedge clk);
    in_valid = 0;
    total++;
    if (out_valid !== 1 || out_miss !== em || out_rank !== er ||
        out_dimm !== ed || out_rank_addr !== ea) begin
      bad++;
      $display("FAIL %s a=%h cp=%0d: got v=%0d m=%0d r=%0d d=%0d ra=%h exp m=%0d r=%0d d=%0d ra=%h",
               tag, a, cp, out_valid, out_miss, out_rank, out_dimm, out_rank_addr,
               em, er, ed, ea);
    end
  endtask

  function automatic string tag_of(input logic [AW-1:0] a, input bit cp);
    bit m; logic [RW-1:0] r; logic [RW-3:0] d; logic [AW-1:0] ra;
    ref_model(a, cp, m, r, d, ra);
    if (m) return "R7 miss";
    return cp ? "R1 R2 R4 R5 R6 closed" : "R1 R3 R4 R5 R6 open";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] acc;
    logic [AW-1:0] hold_addr;
    void'($urandom(32'd4242));
    // increasing limits; rules 0..2 force interleave 1, 2 and 4 (R4)
    acc = '0;
    for (int i = 0; i < NR; i++) begin
      acc = acc + AW'({$urandom() % 32'd16 + 32'd1, 28'h0}) + AW'($urandom() % 32'h10000);
      lim[i] = acc;
      for (int j = 0; j < 4; j++) begin
        of[i][j] = OW'($urandom());
        rk[i][j] = RW'($urandom());
      end
      case (i % 3)
        0: for (int j = 1; j < 4; j++) rk[i][j] = rk[i][0];
        1: begin rk[i][2] = rk[i][0]; rk[i][1] = rk[i][0] ^ 4'h1; rk[i][3] = rk[i][0] ^ 4'h2; end
        default: for (int j = 1; j < 4; j++) rk[i][j] = rk[i][0] ^ RW'(j);
      endcase
    end
    of[0][0] = OW'(-3);   // negative offset (R5)
    of[1][1] = OW'(-1);
    pack_table();
    in_valid = 0; caddr = '0; closed_page = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    total++;
    if (out_valid !== 0 || out_miss !== 0) begin
      bad++; $display("FAIL R9 reset: v=%0d m=%0d exp 0 0", out_valid, out_miss);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 0 || out_miss !== 0) begin
      bad++; $display("FAIL R9 after reset: v=%0d m=%0d exp 0 0", out_valid, out_miss);
    end

    // directed corners
    txn('0, 1, "R1 R2 rule0 zero");
    txn('0, 0, "R1 R3 rule0 zero");
    txn(lim[0], 1, "R1 limit goes to next rule");
    txn(lim[0] - 1, 0, "R1 last address of rule0");
    txn(lim[1] + AW'(37'h40c0), 1, "R4 R5 ilv4 closed");
    txn(lim[0] + AW'(37'h2fff), 0, "R4 R5 ilv2 open");
    txn(lim[NR-1], 0, "R7 miss at top limit");
    txn('1, 1, "R7 miss all ones");
    for (int w = 0; w < 4; w++) txn(AW'(w) << 6 | AW'(5), 1, "R2 R6 way scan closed");
    for (int w = 0; w < 4; w++) txn(AW'(w) << 12 | AW'(37'h123), 0, "R3 R6 way scan open");

    // R8: idle cycle leaves outputs unchanged
    txn(lim[2] + AW'(37'h1234), 0, "R8 setup");
    hold_addr = out_rank_addr;
    caddr = '1; closed_page = 1;
    @(negedge clk);
    total++;
    if (out_valid !== 0 || out_rank_addr !== hold_addr) begin
      bad++; $display("FAIL R8 idle hold: v=%0d ra=%h exp v=0 ra=%h", out_valid, out_rank_addr, hold_addr);
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = rnd_addr() % (lim[NR-1] + AW'(37'h1000000));
      bit cp = $urandom() % 2;
      txn(a, cp, tag_of(a, cp));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule